// File: doc/BRIEF.md
# Reordered Type II Normal Basis Multiplier over GF(2^m)

This block multiplies two elements of the binary field GF(2^m) in one clock cycle. Operands and product all use the reordered type II optimal normal basis. Bit k, for k = 1..m, is the coefficient of gamma^k + gamma^-k. Here gamma is a primitive (2m+1)-th root of unity, so gamma^(2m+1) = 1 and no smaller positive power of gamma is 1. The field width `M` is a parameter. The block is correct for every width where such a basis exists, and M = 5 is the reference configuration.

Every partial product a_i·b_j is steered onto two product positions by index arithmetic alone, and no multiplication matrix is stored. Expanding (gamma^i + gamma^-i)(gamma^j + gamma^-j) gives one term indexed by the difference i−j and one indexed by the sum i+j. A difference folds to |i−j|. A pair with i = j cancels to zero and is dropped. A sum that exceeds M wraps to 2M+1−(i+j). The steering network is fixed when the design is elaborated. A single output register captures the product on every cycle where `in_valid` is high.

The output stage is a two-state machine. ST_EMPTY moves to ST_FULL when `in_valid` is sampled high. ST_FULL stays in ST_FULL while `in_valid` stays high and returns to ST_EMPTY when it is low. ST_EMPTY stays in ST_EMPTY while `in_valid` is low. `out_valid` is high exactly in ST_FULL.

Top module: `rnb_gf_mul`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `c` is all zeros.
- R2: `out_valid` is 1 in the cycle after a clock edge that samples `in_valid` high, and 0 after an edge that samples it low.
- R3: After an edge that samples `in_valid` high, `c` equals the field product of the sampled `a` and `b`. Bit k of each vector is the coefficient of gamma^k + gamma^-k, and exponents are taken modulo 2M+1.
- R4: For one-hot operands a = e_i and b = e_j with i+j <= M, the product is e_{|i−j|} XOR e_{i+j}. When i = j, only e_{2i} remains, because the difference term cancels.
- R5: For one-hot operands a = e_i and b = e_j with i+j > M, the sum term lands on e_{2M+1−(i+j)}. It is XORed with e_{|i−j|} when i ≠ j.
- R6: The product is commutative: swapping `a` and `b` gives the same `c`.
- R7: While `in_valid` is sampled low, `c` keeps its previous value whatever `a` and `b` carry.
- R8: If either operand is zero, the product is zero.
- R9: The all-ones vector is the multiplicative identity: a times all-ones equals a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present; the product is captured at this edge |
| a | input | M | First operand, bits [M:1] in the reordered basis |
| b | input | M | Second operand, bits [M:1] in the reordered basis |
| out_valid | output | 1 | `c` holds a fresh product |
| c | output | M | Registered product, bits [M:1] in the reordered basis |

## Verification
The checker examines four behaviours on every cycle:
- the one-cycle relation between `in_valid` and `out_valid`;
- that `c` holds while no operands are strobed;
- that a zero operand gives a zero result;
- that multiplying by the all-ones identity returns the other operand.

The full field arithmetic needs scenarios from the bench. These cover the correctness of every product, the two folding rules exercised one index pair at a time, and commutativity. The bench compares all operand pairs for M = 5 against a model that accumulates exponents of gamma modulo 2M+1.

// File: rtl/rnb_pkg.sv
package rnb_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;

    // Basis position reached by the difference term of pair (i, j); 0 means cancelled.
    function automatic int diff_pos(input int i, input int j);
        return (i > j) ? (i - j) : (j - i);
    endfunction

    // Basis position reached by the sum term of pair (i, j), wrapped into 1..m.
    function automatic int sum_pos(input int i, input int j, input int m);
        int s;
        s = i + j;
        return (s <= m) ? s : (2 * m + 1 - s);
    endfunction

endpackage

// File: rtl/rnb_pp_array.sv
module rnb_pp_array #(
    parameter int M = 5
) (
    input  logic [M:1]     op_a,
    input  logic [M:1]     op_b,
    output logic [M*M-1:0] pp
);
    // pp[(i-1)*M + (j-1)] = a_i & b_j
    for (genvar gi = 1; gi <= M; gi++) begin : g_row
        for (genvar gj = 1; gj <= M; gj++) begin : g_col
            assign pp[(gi-1)*M + (gj-1)] = op_a[gi] & op_b[gj];
        end
    end
endmodule

// File: rtl/rnb_fold_net.sv
module rnb_fold_net #(
    parameter int M = 5
) (
    input  logic [M*M-1:0] pp,
    output logic [M:1]     prod
);
    import rnb_pkg::*;

    // Each output position XORs every partial product whose folded index lands on it.
    for (genvar gk = 1; gk <= M; gk++) begin : g_pos
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int i = 1; i <= M; i++) begin
                for (int j = 1; j <= M; j++) begin
                    if (diff_pos(i, j) == gk)
                        acc = acc ^ pp[(i-1)*M + (j-1)];
                    if (sum_pos(i, j, M) == gk)
                        acc = acc ^ pp[(i-1)*M + (j-1)];
                end
            end
        end
        assign prod[gk] = acc;
    end
endmodule

// File: rtl/rnb_out_stage.sv
module rnb_out_stage #(
    parameter int M = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [M:1] prod,
    output logic       valid_q,
    output logic [M:1] data_q
);
    import rnb_pkg::*;

    out_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = load ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = load ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (load)
            data_q <= prod;
    end

    assign valid_q = (state_q == ST_FULL);
endmodule

// File: rtl/rnb_gf_mul.sv
module rnb_gf_mul #(
    parameter int M = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [M:1] a,
    input  logic [M:1] b,
    output logic       out_valid,
    output logic [M:1] c
);
    localparam int NPP = M * M;

    logic [NPP-1:0] pp;
    logic [M:1]     prod;

    rnb_pp_array #(.M(M)) u_pp (
        .op_a (a),
        .op_b (b),
        .pp   (pp)
    );

    rnb_fold_net #(.M(M)) u_fold (
        .pp   (pp),
        .prod (prod)
    );

    rnb_out_stage #(.M(M)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .prod    (prod),
        .valid_q (out_valid),
        .data_q  (c)
    );
endmodule

// File: rtl/rnb_gf_mul_chk.sv
module rnb_gf_mul_chk #(
    parameter int M = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [M:1] a,
    input logic [M:1] b,
    input logic       out_valid,
    input logic [M:1] c
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(c));

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a == '0 || b == '0)) |=> (c == '0));

    // R9
    unit_element_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && b == {M{1'b1}}) |=> (c == $past(a)));
endmodule

bind rnb_gf_mul rnb_gf_mul_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .c         (c)
);

// File: tb/test_rnb_gf_mul.sv
`timescale 1ns/1ps
module test_rnb_gf_mul;
    localparam int M = 5;
    localparam int N = 2 * M + 1;
    localparam int NVAL = 1 << M;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [M:1] a = '0;
    logic [M:1] b = '0;
    logic       out_valid;
    logic [M:1] c;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rnb_gf_mul #(.M(M)) i_rnb_gf_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .c         (c)
    );

    // Model: expand into powers of gamma modulo 2M+1, then read coefficient k.
    function automatic logic [M:1] model(input logic [M:1] x, input logic [M:1] y);
        bit [N-1:0] coef;
        logic [M:1] r;
        coef = '0;
        for (int i = 1; i <= M; i++) begin
            for (int j = 1; j <= M; j++) begin
                if (x[i] && y[j]) begin
                    coef[(i + j) % N]         ^= 1'b1;
                    coef[(2 * N - i - j) % N] ^= 1'b1;
                    coef[(N + i - j) % N]     ^= 1'b1;
                    coef[(N + j - i) % N]     ^= 1'b1;
                end
            end
        end
        for (int k = 1; k <= M; k++) r[k] = coef[k];
        return r;
    endfunction

    function automatic logic [M:1] onehot(input int k);
        logic [M:1] r;
        r = '0;
        if (k >= 1 && k <= M) r[k] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [M:1] act, input logic [M:1] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at a falling edge, capture on the rising edge, sample at the next falling edge.
    task automatic op(input logic [M:1] x, input logic [M:1] y,
                      input string req, input logic [M:1] exp);
        a = x; b = y; in_valid = 1'b1;
        @(negedge clk);
        check(req, c, exp);
        check("R2", {{(M-1){1'b0}}, out_valid}, {{(M-1){1'b0}}, 1'b1});
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [M:1] held;
        repeat (3) @(negedge clk);
        check("R1", c, '0);
        check("R1", {{(M-1){1'b0}}, out_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", {{(M-1){1'b0}}, out_valid}, '0);

        // R3: every operand pair against the exponent model
        for (int x = 0; x < NVAL; x++)
            for (int y = 0; y < NVAL; y++)
                op(x[M-1:0], y[M-1:0], "R3", model(x[M-1:0], y[M-1:0]));

        // R6: swapped operands must give the product of the unswapped pair
        for (int x = 0; x < NVAL; x++)
            for (int y = 0; y < NVAL; y++)
                op(y[M-1:0], x[M-1:0], "R6", model(x[M-1:0], y[M-1:0]));

        // R4 / R5: one-hot pairs with the folding rules written out
        for (int i = 1; i <= M; i++) begin
            for (int j = 1; j <= M; j++) begin
                logic [M:1] e;
                int d;
                d = (i > j) ? i - j : j - i;
                e = onehot(d);
                if (i + j <= M) begin
                    e ^= onehot(i + j);
                    op(onehot(i), onehot(j), "R4", e);
                end else begin
                    e ^= onehot(2 * M + 1 - i - j);
                    op(onehot(i), onehot(j), "R5", e);
                end
            end
        end

        // R8: zero operand on either side
        for (int y = 0; y < NVAL; y++) begin
            op('0, y[M-1:0], "R8", '0);
            op(y[M-1:0], '0, "R8", '0);
        end

        // R9: all-ones is the identity
        for (int x = 0; x < NVAL; x++)
            op(x[M-1:0], {M{1'b1}}, "R9", x[M-1:0]);

        // R7: operands change with in_valid low, the result must not move
        op(5'b10110, 5'b01011, "R3", model(5'b10110, 5'b01011));
        held = c;
        for (int x = 1; x < 8; x++) begin
            in_valid = 1'b0;
            a = x[M-1:0] ^ 5'b10101;
            b = ~x[M-1:0];
            @(negedge clk);
            check("R7", c, held);
            check("R2", {{(M-1){1'b0}}, out_valid}, '0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule